// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches forty external request lines. Each line has its own mask and edge selection. The block records a pending flag when an enabled edge arrives and marks the moment with a single-cycle pulse on the output for that line. The lines are split into two banks: a low bank of 32 lines and a high bank of 8 lines. Each bank has six 32-bit registers, reached through a plain register port that accepts a single access per cycle and returns read data one cycle later. Software can also raise a line by setting its trigger bit, and it retires a pending flag by writing a one to that flag.

Some positions are wired-through lines that never use the edge logic. For these positions the edge-select, trigger and pending bits always read zero. Their interrupt-mask bits start set after reset. A summary output is high while any pending flag in either bank is set.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the low-bank interrupt mask reads 0xFF820000 and the high-bank interrupt mask reads 0x00000087. Every other register reads zero, and every pulse output and the summary output are low.
- R2: The word offsets are interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10 and pending 0x14 for the low bank. The high bank uses the same order at 0x20 to 0x34. A written value can be read back from its offset.
- R3: All 32 bits of the low bank's interrupt and event masks are writable. In the high bank only bits 7:0 are stored, and bits 31:8 read zero.
- R4: Writes to the rising select, falling select, software trigger and pending registers leave the wired-through positions at zero. These positions are low-bank mask 0xFF820000 and high-bank mask 0x00000087.
- R5: A 0-to-1 change on an input whose mask bit and rising-select bit are set makes that line pending. Two clock edges after the input changes, it also gives a one-cycle pulse. If the mask bit is clear, the change has no effect.
- R6: A 1-to-0 change on an input whose mask bit and falling-select bit are set makes that line pending and pulses it, with the same timing as R5.
- R7: A software-trigger write pends, and pulses on the next cycle, only the bits that change from 0 to 1 in that register, are unmasked, and are not already pending. The register then holds the written value with the wired-through positions removed.
- R8: Writing 1 to a pending bit clears that bit and also clears the same bit of the software trigger. Writing 0 to a pending bit leaves it as it was.
- R9: If an enabled edge and a clearing write reach the same pending bit in the same cycle, the bit stays set.
- R10: Accesses with a nonzero address bits 1:0, and offsets 0x18, 0x1C, 0x38, 0x3C or 0x40 and above, are undefined. Reads of them return zero, and writes to them change nothing.
- R11: The summary output is the OR of all forty pending bits.
- R12: Read data appears on the clock edge that accepts the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the inputs and the register port |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 40 | Input levels; bits 31:0 go to the low bank and bits 39:32 to the high bank |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| line_pulse | output | 40 | One-cycle pulse for each line that becomes pending |
| irq_any | output | 1 | High while any line is pending |

## Verification
The hardest case to reach is the race in which a new edge and a write-one-to-clear land on the same pending bit on the same clock edge. The edge only acts two edges after the input moves, so the stimulus raises the input one cycle before it issues the clearing write. A second hard case is a trigger rewrite on a bit that is already set or already pending. This is reached by writing the same trigger value twice, and by writing it again after a clear. A behavioural model checks every cycle while a long random mix of level changes and register traffic, including undefined and unaligned offsets, runs against it.

// File: rtl/exti_pkg.sv
package exti_pkg;
  typedef logic [31:0] word_t;

  typedef enum logic [2:0] {
    REG_IMASK = 3'd0,
    REG_EMASK = 3'd1,
    REG_RISE  = 3'd2,
    REG_FALL  = 3'd3,
    REG_SWT   = 3'd4,
    REG_PEND  = 3'd5
  } reg_sel_e;

  // lines hit by a hardware edge this cycle
  function automatic word_t edge_hits(word_t mask, word_t rise, word_t fall,
                                      word_t rsel, word_t fsel);
    return mask & ((rise & rsel) | (fall & fsel));
  endfunction

  // trigger bits that newly pend: fresh 0->1, unmasked, not yet pending
  function automatic word_t trig_hits(word_t wr_set, word_t old_trig,
                                      word_t mask, word_t pend);
    return wr_set & ~old_trig & mask & ~pend;
  endfunction

  // pending bits retired by a write-one-to-clear
  function automatic word_t clear_bits(word_t pend, word_t wd, word_t fixed);
    return pend & wd & ~fixed;
  endfunction
endpackage

// File: rtl/exti_edge.sv
module exti_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] cur_q;
  logic [W-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      prv_q <= '0;
    end else begin
      cur_q <= lvl;
      prv_q <= cur_q;
    end
  end

  assign rise = cur_q & ~prv_q;
  assign fall = ~cur_q & prv_q;
endmodule

// File: rtl/exti_bank.sv
module exti_bank
  import exti_pkg::*;
#(
  parameter int          W      = 32,
  parameter logic [31:0] FIXED  = 32'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic         we,
  input  reg_sel_e     sel,
  input  logic [31:0]  wdata,
  output logic [31:0]  rdval,
  output logic [W-1:0] pend,
  output logic [W-1:0] pulse
);
  localparam logic [W-1:0] FIX_W   = FIXED[W-1:0];
  localparam logic [W-1:0] TRIG_OK = ~FIX_W;

  logic [W-1:0] imr, emr, rsel, fsel, trig;
  logic [W-1:0] wd;
  logic [W-1:0] hw_hit, sw_hit, clr;
  logic         swt_wr, pend_wr;

  assign wd      = W'(wdata);
  assign swt_wr  = we && (sel == REG_SWT);
  assign pend_wr = we && (sel == REG_PEND);

  always_comb begin
    hw_hit = W'(edge_hits(32'(imr), 32'(rise), 32'(fall), 32'(rsel), 32'(fsel)));
    sw_hit = swt_wr ? W'(trig_hits(32'(wd & TRIG_OK), 32'(trig), 32'(imr), 32'(pend))) : '0;
    clr    = pend_wr ? W'(clear_bits(32'(pend), 32'(wd), 32'(FIX_W))) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr   <= FIX_W;
      emr   <= '0;
      rsel  <= '0;
      fsel  <= '0;
      trig  <= '0;
      pend  <= '0;
      pulse <= '0;
    end else begin
      if (we) begin
        unique case (sel)
          REG_IMASK: imr  <= wd;
          REG_EMASK: emr  <= wd;
          REG_RISE:  rsel <= wd & TRIG_OK;
          REG_FALL:  fsel <= wd & TRIG_OK;
          REG_SWT:   trig <= wd & TRIG_OK;
          REG_PEND:  trig <= trig & ~clr;
          default:   ;
        endcase
      end
      // new edges are ORed after the clear, so they win a same-cycle race
      pend  <= (pend & ~clr) | hw_hit | sw_hit;
      pulse <= hw_hit | sw_hit;
    end
  end

  always_comb begin
    unique case (sel)
      REG_IMASK: rdval = 32'(imr);
      REG_EMASK: rdval = 32'(emr);
      REG_RISE:  rdval = 32'(rsel);
      REG_FALL:  rdval = 32'(fsel);
      REG_SWT:   rdval = 32'(trig);
      REG_PEND:  rdval = 32'(pend);
      default:   rdval = '0;
    endcase
  end

  // R1: reset leaves only the wired-through lines unmasked, nothing pending
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (imr == FIX_W && pend == '0 && pulse == '0));

  // R5: a pulsing line is pending in the same cycle
  assert_pulse_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse & ~pend) == '0);

  // R5: a line that was masked never becomes pending
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(imr)) == '0);

  // R7: a trigger write never re-pulses a line that was already pending
  assert_trig_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swt_wr |=> ((pulse & $past(pend) & ~$past(hw_hit)) == '0));

  // R8/R9: a cleared bit without a fresh hit is gone on the next cycle
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend & $past(clr & ~hw_hit)) == '0));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import exti_pkg::*;
#(
  parameter int          LINES_LO = 32,
  parameter int          LINES_HI = 8,
  parameter logic [31:0] FIXED_LO = 32'hFF82_0000,
  parameter logic [31:0] FIXED_HI = 32'h0000_0087,
  parameter int          ADDR_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LINES_LO+LINES_HI-1:0] line_in,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [31:0]                  req_wdata,
  output logic [31:0]                  rd_data,
  output logic [LINES_LO+LINES_HI-1:0] line_pulse,
  output logic                         irq_any
);
  localparam int NLINES = LINES_LO + LINES_HI;
  localparam int NBANK  = 2;

  logic [NLINES-1:0] pend_all;
  logic [31:0]       bank_rd [NBANK];
  logic              bank_idx;
  reg_sel_e          sel;
  logic              acc_ok;

  assign bank_idx = req_addr[5];
  assign sel      = reg_sel_e'(req_addr[4:2]);
  assign acc_ok   = req_valid && (req_addr[1:0] == 2'b00) &&
                    (req_addr[ADDR_W-1:6] == '0) && (req_addr[4:2] <= 3'd5);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int          W  = (b == 0) ? LINES_LO : LINES_HI;
    localparam int          LO = (b == 0) ? 0 : LINES_LO;
    localparam logic [31:0] FX = (b == 0) ? FIXED_LO : FIXED_HI;

    logic [W-1:0] rise, fall;
    logic         we;

    assign we = acc_ok && req_write && (bank_idx == 1'(b));

    exti_edge #(.W(W)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (line_in[LO +: W]),
      .rise (rise),
      .fall (fall)
    );

    exti_bank #(.W(W), .FIXED(FX)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .rise (rise),
      .fall (fall),
      .we   (we),
      .sel  (sel),
      .wdata(req_wdata),
      .rdval(bank_rd[b]),
      .pend (pend_all[LO +: W]),
      .pulse(line_pulse[LO +: W])
    );
  end

  assign irq_any = |pend_all;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (req_valid && !req_write) rd_data <= acc_ok ? bank_rd[bank_idx] : '0;
  end

  // R10: a read of an undefined or unaligned offset returns zero
  assert_bad_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !acc_ok) |=> (rd_data == '0));

  // R12: read data holds while no read is issued
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rd_data));
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] line_in = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic [39:0] line_pulse;
  logic        irq_any;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .line_pulse(line_pulse),
    .irq_any(irq_any)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] fixed_m [2] = '{32'hFF82_0000, 32'h0000_0087};
  logic [31:0] width_m [2] = '{32'hFFFF_FFFF, 32'h0000_00FF};
  logic [31:0] m_reg [2][6];   // [bank][0 mask,1 event,2 rise,3 fall,4 trig,5 pend]
  logic [39:0] m_now = '0, m_old = '0, m_pulse = '0;
  logic [31:0] m_rd = '0;

  function automatic logic [31:0] bank_of(logic [39:0] v, int b);
    return (b == 0) ? v[31:0] : {24'h0, v[39:32]};
  endfunction

  always @(posedge clk) begin
    logic [31:0] up, dn, fired [2], cut;
    int b, k;
    logic ok;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 6; j++) m_reg[i][j] = (j == 0) ? fixed_m[i] : 32'h0;
      m_now = '0; m_old = '0; m_pulse = '0; m_rd = '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        up = bank_of(m_now, i) & ~bank_of(m_old, i);
        dn = ~bank_of(m_now, i) & bank_of(m_old, i);
        fired[i] = m_reg[i][0] & ((up & m_reg[i][2]) | (dn & m_reg[i][3]));
      end
      cut = 0;
      b = int'(req_addr[5]);
      k = int'(req_addr[4:2]);
      ok = (req_addr[1:0] == 0) && (req_addr < 8'h40) && (k < 6);
      if (req_valid && !req_write) m_rd = ok ? m_reg[b][k] : 32'h0;
      if (req_valid && req_write && ok) begin
        logic [31:0] v;
        v = req_wdata & width_m[b];
        if (k < 2) m_reg[b][k] = v;
        else if (k < 4) m_reg[b][k] = v & ~fixed_m[b];
        else if (k == 4) begin
          v = v & ~fixed_m[b];
          fired[b] = fired[b] | (v & ~m_reg[b][4] & m_reg[b][0] & ~m_reg[b][5]);
          m_reg[b][4] = v;
        end else begin
          cut = m_reg[b][5] & v & ~fixed_m[b];
          m_reg[b][4] = m_reg[b][4] & ~cut;
        end
      end
      for (int i = 0; i < 2; i++)
        m_reg[i][5] = (m_reg[i][5] & ~((b == i) ? cut : 32'h0)) | fired[i];
      m_pulse = {fired[1][7:0], fired[0]};
      m_old = m_now;
      m_now = line_in;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      vectors++;
      if (line_pulse !== m_pulse) begin
        miscompares++;
        $display("FAIL R5 line_pulse act=%h exp=%h", line_pulse, m_pulse);
      end
      if (irq_any !== (|{m_reg[1][5], m_reg[0][5]})) begin
        miscompares++;
        $display("FAIL R11 irq_any act=%b exp=%b", irq_any, |{m_reg[1][5], m_reg[0][5]});
      end
      if (rd_data !== m_rd) begin
        miscompares++;
        $display("FAIL R12 rd_data act=%h exp=%h", rd_data, m_rd);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rd_data;
  endtask

  task automatic set_line(int idx, logic v);
    @(negedge clk);
    line_in[idx] = v;
    repeat (3) @(negedge clk);
  endtask

  logic done = 0;

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pulses", 32'(line_pulse), 32'h0);
    chk("R1 irq_any", 32'(irq_any), 32'h0);
    rd(8'h00, d); chk("R1 mask lo", d, 32'hFF82_0000);
    rd(8'h20, d); chk("R1 mask hi", d, 32'h0000_0087);
    rd(8'h14, d); chk("R1 pend lo", d, 32'h0);
    rd(8'h08, d); chk("R1 rise lo", d, 32'h0);

    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 mask lo", d, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, d); chk("R3 event hi", d, 32'h0000_00FF);
    wr(8'h04, 32'h1234_5678); rd(8'h04, d); chk("R3 event lo", d, 32'h1234_5678);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R4 rise lo", d, 32'h007D_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, d); chk("R4 fall hi", d, 32'h0000_0078);
    @(negedge clk);
    chk("R12 hold", rd_data, 32'h0000_0078);

    set_line(3, 1);
    rd(8'h14, d); chk("R5 rise pend", d, 32'h8);
    chk("R11 any set", 32'(irq_any), 32'h1);
    wr(8'h14, 32'h8); rd(8'h14, d); chk("R8 clear", d, 32'h0);
    chk("R11 any clear", 32'(irq_any), 32'h0);

    wr(8'h00, 32'hFFFF_FFEF);
    set_line(4, 1);
    rd(8'h14, d); chk("R5 masked", d, 32'h0);

    wr(8'h0C, 32'h8);
    set_line(3, 0);
    rd(8'h14, d); chk("R6 fall pend", d, 32'h8);
    wr(8'h14, 32'h8);

    wr(8'h10, 32'h100); rd(8'h14, d); chk("R7 sw pend", d, 32'h100);
    rd(8'h10, d); chk("R7 sw value", d, 32'h100);
    wr(8'h10, 32'h100); rd(8'h14, d); chk("R7 no refire", d, 32'h100);
    wr(8'h14, 32'h100); rd(8'h14, d); chk("R8 sw clear pend", d, 32'h0);
    rd(8'h10, d); chk("R8 sw clear trig", d, 32'h0);
    wr(8'h10, 32'h100); rd(8'h14, d); chk("R7 refire", d, 32'h100);
    wr(8'h14, 32'h100);
    wr(8'h10, 32'hFF82_0001); rd(8'h10, d); chk("R4 trig fixed", d, 32'h1);
    rd(8'h14, d); chk("R7 sw bit0", d, 32'h1);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); chk("R4 pend clear", d, 32'h0);
    wr(8'h10, 32'h10); rd(8'h14, d); chk("R7 masked sw", d, 32'h0);
    wr(8'h10, 32'h50); rd(8'h14, d); chk("R7 partial", d, 32'h40);
    wr(8'h14, 32'h0); rd(8'h14, d); chk("R8 zero write", d, 32'h40);
    wr(8'h14, 32'h40);

    // R9: edge and clear meet on the same clock edge
    wr(8'h10, 32'h20);
    @(negedge clk);
    line_in[5] = 1;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h14; req_wdata = 32'h20;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd(8'h14, d); chk("R9 edge wins", d, 32'h20);
    rd(8'h10, d); chk("R9 trig cleared", d, 32'h0);
    wr(8'h14, 32'h20);

    wr(8'h20, 32'hFF); wr(8'h28, 32'h8);
    set_line(35, 1);
    rd(8'h34, d); chk("R5 hi bank", d, 32'h8);
    wr(8'h34, 32'h8);
    wr(8'h28, 32'hFF);
    set_line(32, 1);
    rd(8'h34, d); chk("R4 fixed line", d, 32'h0);

    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, d); chk("R10 hole", d, 32'h0);
    wr(8'h01, 32'h0); rd(8'h00, d); chk("R10 unaligned wr", d, 32'hFFFF_FFEF);
    rd(8'h02, d); chk("R10 unaligned rd", d, 32'h0);
    rd(8'h3C, d); chk("R10 hi hole", d, 32'h0);
    wr(8'h40, 32'h0); rd(8'h40, d); chk("R10 beyond", d, 32'h0);
    rd(8'h00, d); chk("R10 beyond wr", d, 32'hFFFF_FFEF);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (($urandom % 4) == 0) line_in[$urandom % 40] ^= 1'b1;
      req_valid = (($urandom % 3) == 0);
      req_write = $urandom % 2;
      req_addr  = (($urandom % 8) == 0) ? 8'($urandom) : {2'b00, 4'($urandom), 2'b00};
      req_wdata = (($urandom % 2) == 0) ? $urandom : (32'h1 << ($urandom % 32));
    end
    @(negedge clk);
    req_valid = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule